// File: doc/BRIEF.md
# Host-to-Port Packet Ingress Handshake Controller

This block is the device-side control for packets that a host pushes into a switch device. The host first asks for a buffer. The controller picks the lowest free local buffer block and grants the ports whose links are up. It then writes a reply word into a 32-entry ring in host memory, at an address built from a configurable ring base. A reply with a zero byte count refuses the request. This happens when every block is taken, when no requested port has its link up, or when the request asked for zero bytes. After a refusal the host sends nothing more for that request.

After a grant, the host streams data words into the granted block and closes with an end-of-packet message. That message names the block, the byte count, a unicast port or a multicast port mask, and a flag that asks for a checksum to be appended. The controller checks the message and keeps only the ports that were granted, raising a violation pulse if the host named any other port. It then writes a transmit descriptor into the queue of each surviving port. Each port drains its queue in order and reports each finished transmission with a done pulse. A per-block reference count returns the block to the free pool once the last port has finished with it.

Top module: `pic_ingress_ctl`

## Requirements
- R1: After reset no block is busy, no port has a pending descriptor, and `rp_valid`, `mem_we`, `eop_mask_viol` and `eop_bad` are low.
- R2: A request (kind 1; data[7:0] = wanted port mask, data[19:8] = byte count) gives a reply one cycle later when a block is free, the wanted mask ANDed with `link_up` is nonzero, and the byte count is nonzero. The reply holds the byte count in [11:0], the lowest free block index in [14:12] and the granted mask (wanted AND `link_up`) in [23:16]. The granted block shows as busy in the same cycle as the reply.
- R3: A request whose granted mask is zero, or that finds no free block, is refused. The reply word is all zero and no block is allocated.
- R4: Every reply, granted or refused, goes to ring base + 4 × index. The index starts at 0 and wraps modulo 32.
- R5: A data write (kind 2) whose `hw_addr` = {block, word offset} names a block that awaits its end-of-packet appears on the memory port one cycle later. A data write to any other block is dropped.
- R6: A unicast end-of-packet (kind 3; [11:0] byte count, [14:12] block, [18:16] port, [20] checksum flag, [21] = 0) queues a descriptor {block, byte count, flag} at that port. The descriptor is visible one cycle later.
- R7: A multicast end-of-packet ([21] = 1) queues the descriptor at every port set in data[29:22] that was also granted.
- R8: Any port named in an end-of-packet message but not granted is dropped, and `eop_mask_viol` pulses for one cycle.
- R9: An end-of-packet message naming a block that does not await one pulses `eop_bad` and changes no queue and no block.
- R10: Each port queue is first-in first-out. `tx_done` on a port with no pending descriptor has no effect.
- R11: A block stays busy until every port it was queued to has reported `tx_done` for it. Its busy bit clears one cycle after the last such pulse, or one cycle after the end-of-packet message if no port survives the check.
- R12: A configuration write (kind 0) sets the ring base for later replies and leaves the ring index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_valid | input | 1 | Host message valid |
| hw_kind | input | 2 | 0 config, 1 buffer request, 2 data, 3 end-of-packet |
| hw_data | input | 32 | Message payload |
| hw_addr | input | 9 | Data write target {block, word offset} |
| link_up | input | 8 | Per-port link status |
| tx_done | input | 8 | Per-port pulse: head descriptor transmitted |
| rp_valid | output | 1 | Reply write strobe |
| rp_addr | output | 32 | Reply write address in the host ring |
| rp_data | output | 32 | Reply word |
| mem_we | output | 1 | Buffer memory write enable |
| mem_addr | output | 9 | Buffer memory word address |
| mem_wdata | output | 32 | Buffer memory write data |
| blk_busy | output | 8 | Bitmap of blocks in use |
| tx_pending | output | 8 | Per-port queue not empty |
| tx_head_blk | output | 8x3 | Per-port head descriptor block |
| tx_head_bc | output | 8x12 | Per-port head descriptor byte count |
| tx_head_crc | output | 8 | Per-port head descriptor checksum flag |
| eop_mask_viol | output | 1 | Pulse: end-of-packet named a port that was not granted |
| eop_bad | output | 1 | Pulse: end-of-packet named a block that does not await one |

## Verification
Buffer requests run with all links up, with some links down, with all links down, and against a full pool. These cases separate the lowest-free selection and the link masking from the refusal path. End-of-packet messages are sent as unicast, as multicast with a port that was not granted, with no surviving port, and with a stale block. Each case shows which queues fill, whether the violation and bad pulses fire, and when the block returns to the pool. Done pulses are sent on several ports at once, in sequence on one port, and on an empty port. These cases show that the reference count releases a block only after its last port finishes, and that each queue keeps its order. A long run of refused requests, followed by a base change, shows the ring index wrapping and being kept across the change.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int PORTS  = 8;
    localparam int BLOCKS = 8;
    localparam int BLK_W  = $clog2(BLOCKS);
    localparam int BC_W   = 12;
    localparam int WOFF_W = 6;
    localparam int RING_N = 32;
    localparam int RING_W = $clog2(RING_N);
    localparam int CNT_W  = $clog2(PORTS + 1);
    localparam int ADDR_W = BLK_W + WOFF_W;

    // field positions in message and reply words
    localparam int F_BLK   = 12;
    localparam int F_RMASK = 16;
    localparam int F_PORT  = 16;
    localparam int F_CRC   = 20;
    localparam int F_MC    = 21;
    localparam int F_EMASK = 22;
    localparam int F_QBC   = 8;

    typedef enum logic [1:0] {
        MSG_CFG  = 2'd0,
        MSG_REQ  = 2'd1,
        MSG_DATA = 2'd2,
        MSG_EOP  = 2'd3
    } msg_kind_e;

    typedef struct packed {
        logic              crc;
        logic [BC_W-1:0]   bc;
        logic [BLK_W-1:0]  blk;
    } desc_t;

    function automatic logic [BLK_W:0] first_free(input logic [BLOCKS-1:0] busy);
        logic [BLK_W:0] r;
        r = '0;
        for (int i = BLOCKS - 1; i >= 0; i--) begin
            if (!busy[i]) r = {1'b1, BLK_W'(i)};
        end
        return r;
    endfunction

    function automatic logic [31:0] pack_reply(input logic [BC_W-1:0] bc,
                                               input logic [BLK_W-1:0] blk,
                                               input logic [PORTS-1:0] mask);
        logic [31:0] w;
        w = '0;
        w[BC_W-1:0]          = bc;
        w[F_BLK +: BLK_W]    = blk;
        w[F_RMASK +: PORTS]  = mask;
        return w;
    endfunction
endpackage

// File: rtl/pic_blk_pool.sv
module pic_blk_pool
    import pic_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              alloc_en,
    input  logic [PORTS-1:0]                  alloc_mask,
    input  logic                              eop_en,
    input  logic [BLK_W-1:0]                  eop_blk,
    input  logic [PORTS-1:0]                  eop_final,
    input  logic [BLOCKS-1:0][CNT_W-1:0]      rel_dec,
    output logic                              free_any,
    output logic [BLK_W-1:0]                  free_idx,
    output logic [BLOCKS-1:0]                 busy,
    output logic [BLOCKS-1:0]                 pend,
    output logic [BLOCKS-1:0][PORTS-1:0]      gmask
);
    logic [BLOCKS-1:0][CNT_W-1:0] refcnt;
    logic [BLK_W:0]               pick;

    assign pick     = first_free(busy);
    assign free_any = pick[BLK_W];
    assign free_idx = pick[BLK_W-1:0];

    for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
        logic take;
        logic close;
        assign take  = alloc_en && free_idx == BLK_W'(b);
        assign close = eop_en && eop_blk == BLK_W'(b);

        always_ff @(posedge clk) begin
            if (rst) begin
                busy[b]   <= 1'b0;
                pend[b]   <= 1'b0;
                gmask[b]  <= '0;
                refcnt[b] <= '0;
            end else if (close) begin
                pend[b]   <= 1'b0;
                refcnt[b] <= CNT_W'($countones(eop_final));
                if (eop_final == '0) busy[b] <= 1'b0;
            end else if (take) begin
                busy[b]   <= 1'b1;
                pend[b]   <= 1'b1;
                gmask[b]  <= alloc_mask;
                refcnt[b] <= '0;
            end else if (rel_dec[b] != '0) begin
                refcnt[b] <= refcnt[b] - rel_dec[b];
                if (refcnt[b] == rel_dec[b]) busy[b] <= 1'b0;
            end
        end

        // a free block carries no references and awaits no end-of-packet
        assert_free_block_clean_R11: assert property (@(posedge clk) disable iff (rst)
            !busy[b] |-> (refcnt[b] == '0 && !pend[b]));
    end
endmodule

// File: rtl/pic_port_fifo.sv
module pic_port_fifo
    import pic_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  desc_t push_desc,
    input  logic  pop,
    output logic  pending,
    output desc_t head
);
    localparam int QA = BLK_W + 1;

    desc_t          store [BLOCKS];
    logic [QA-1:0]  wr_ptr;
    logic [QA-1:0]  rd_ptr;
    logic           full;

    assign pending = wr_ptr != rd_ptr;
    assign full    = (wr_ptr[BLK_W] != rd_ptr[BLK_W]) &&
                     (wr_ptr[BLK_W-1:0] == rd_ptr[BLK_W-1:0]);
    assign head    = store[rd_ptr[BLK_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) begin
                store[wr_ptr[BLK_W-1:0]] <= push_desc;
                wr_ptr <= wr_ptr + QA'(1);
            end
            if (pop && pending) rd_ptr <= rd_ptr + QA'(1);
        end
    end

    // a block is queued at most once per port, so the queue never overflows
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
endmodule

// File: rtl/pic_reply_ring.sv
module pic_reply_ring
    import pic_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_en,
    input  logic [31:0] cfg_base,
    input  logic        post_en,
    input  logic [31:0] post_word,
    output logic        rp_valid,
    output logic [31:0] rp_addr,
    output logic [31:0] rp_data
);
    logic [31:0]       base;
    logic [RING_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            base     <= '0;
            idx      <= '0;
            rp_valid <= 1'b0;
            rp_addr  <= '0;
            rp_data  <= '0;
        end else begin
            rp_valid <= post_en;
            if (cfg_en) base <= cfg_base;
            if (post_en) begin
                rp_addr <= base + {{(30 - RING_W){1'b0}}, idx, 2'b00};
                rp_data <= post_word;
                idx     <= idx + RING_W'(1);
            end
        end
    end
endmodule

// File: rtl/pic_ingress_ctl.sv
module pic_ingress_ctl
    import pic_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          hw_valid,
    input  logic [1:0]                    hw_kind,
    input  logic [31:0]                   hw_data,
    input  logic [ADDR_W-1:0]             hw_addr,
    input  logic [PORTS-1:0]              link_up,
    input  logic [PORTS-1:0]              tx_done,
    output logic                          rp_valid,
    output logic [31:0]                   rp_addr,
    output logic [31:0]                   rp_data,
    output logic                          mem_we,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [31:0]                   mem_wdata,
    output logic [BLOCKS-1:0]             blk_busy,
    output logic [PORTS-1:0]              tx_pending,
    output logic [PORTS-1:0][BLK_W-1:0]   tx_head_blk,
    output logic [PORTS-1:0][BC_W-1:0]    tx_head_bc,
    output logic [PORTS-1:0]              tx_head_crc,
    output logic                          eop_mask_viol,
    output logic                          eop_bad
);
    msg_kind_e kind;
    logic is_cfg, is_req, is_data, is_eop;

    assign kind    = msg_kind_e'(hw_kind);
    assign is_cfg  = hw_valid && kind == MSG_CFG;
    assign is_req  = hw_valid && kind == MSG_REQ;
    assign is_data = hw_valid && kind == MSG_DATA;
    assign is_eop  = hw_valid && kind == MSG_EOP;

    // pool signals
    logic                          free_any;
    logic [BLK_W-1:0]              free_idx;
    logic [BLOCKS-1:0]             pend;
    logic [BLOCKS-1:0][PORTS-1:0]  gmask;
    logic [BLOCKS-1:0][CNT_W-1:0]  rel_dec;

    // buffer request decode
    logic [PORTS-1:0] req_mask;
    logic [BC_W-1:0]  req_bc;
    logic             grant;
    logic [31:0]      reply_word;

    assign req_mask   = hw_data[PORTS-1:0] & link_up;
    assign req_bc     = hw_data[F_QBC +: BC_W];
    assign grant      = is_req && free_any && (req_mask != '0) && (req_bc != '0);
    assign reply_word = grant ? pack_reply(req_bc, free_idx, req_mask) : '0;

    // end-of-packet decode
    logic [BLK_W-1:0] e_blk;
    logic [2:0]       e_port;
    logic [PORTS-1:0] e_want;
    logic [PORTS-1:0] e_final;
    logic             eop_ok;
    desc_t            e_desc;

    assign e_blk   = hw_data[F_BLK +: BLK_W];
    assign e_port  = hw_data[F_PORT +: 3];
    assign e_want  = hw_data[F_MC] ? hw_data[F_EMASK +: PORTS]
                                   : PORTS'(1) << e_port;
    assign e_final = e_want & gmask[e_blk];
    assign eop_ok  = is_eop && pend[e_blk];
    assign e_desc  = '{crc: hw_data[F_CRC], bc: hw_data[BC_W-1:0], blk: e_blk};

    logic unused_bits;
    assign unused_bits = ^{hw_data[31:30], hw_data[19], hw_data[15]};

    // data write gate
    logic [BLK_W-1:0] d_blk;
    assign d_blk = hw_addr[ADDR_W-1 -: BLK_W];

    // queues
    desc_t            heads [PORTS];
    logic [PORTS-1:0] pop;

    assign pop = tx_done & tx_pending;

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        pic_port_fifo u_q (
            .clk       (clk),
            .rst       (rst),
            .push      (eop_ok && e_final[p]),
            .push_desc (e_desc),
            .pop       (pop[p]),
            .pending   (tx_pending[p]),
            .head      (heads[p])
        );
        assign tx_head_blk[p] = heads[p].blk;
        assign tx_head_bc[p]  = heads[p].bc;
        assign tx_head_crc[p] = heads[p].crc;
    end

    always_comb begin
        for (int b = 0; b < BLOCKS; b++) begin
            rel_dec[b] = '0;
            for (int p = 0; p < PORTS; p++) begin
                if (pop[p] && heads[p].blk == BLK_W'(b))
                    rel_dec[b] = rel_dec[b] + CNT_W'(1);
            end
        end
    end

    pic_blk_pool u_pool (
        .clk        (clk),
        .rst        (rst),
        .alloc_en   (grant),
        .alloc_mask (req_mask),
        .eop_en     (eop_ok),
        .eop_blk    (e_blk),
        .eop_final  (e_final),
        .rel_dec    (rel_dec),
        .free_any   (free_any),
        .free_idx   (free_idx),
        .busy       (blk_busy),
        .pend       (pend),
        .gmask      (gmask)
    );

    pic_reply_ring u_ring (
        .clk       (clk),
        .rst       (rst),
        .cfg_en    (is_cfg),
        .cfg_base  (hw_data),
        .post_en   (is_req),
        .post_word (reply_word),
        .rp_valid  (rp_valid),
        .rp_addr   (rp_addr),
        .rp_data   (rp_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we        <= 1'b0;
            mem_addr      <= '0;
            mem_wdata     <= '0;
            eop_mask_viol <= 1'b0;
            eop_bad       <= 1'b0;
        end else begin
            mem_we        <= is_data && pend[d_blk];
            mem_addr      <= hw_addr;
            mem_wdata     <= hw_data;
            eop_mask_viol <= eop_ok && ((e_want & ~gmask[e_blk]) != '0);
            eop_bad       <= is_eop && !pend[e_blk];
        end
    end

    // granted ports were up when the request was taken
    assert_grant_link_R2: assert property (@(posedge clk) disable iff (rst)
        rp_valid |-> ((rp_data[F_RMASK +: PORTS] & ~$past(link_up)) == '0));

    // a forwarded data write always lands in a block held by the pool
    assert_data_target_busy_R5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> blk_busy[mem_addr[ADDR_W-1 -: BLK_W]]);

    // a stale end-of-packet is never also reported as a mask violation
    assert_bad_not_viol_R9: assert property (@(posedge clk) disable iff (rst)
        eop_bad |-> !eop_mask_viol);

    // a refused reply grants no ports
    assert_refusal_empty_R3: assert property (@(posedge clk) disable iff (rst)
        (rp_valid && rp_data[BC_W-1:0] == '0) |-> (rp_data[F_RMASK +: PORTS] == '0));
endmodule

// File: tb/pic_ingress_ctl_tb_top.sv
module pic_ingress_ctl_tb_top;
    import pic_pkg::*;

    logic                          clk = 1'b0;
    logic                          rst;
    logic                          hw_valid;
    logic [1:0]                    hw_kind;
    logic [31:0]                   hw_data;
    logic [ADDR_W-1:0]             hw_addr;
    logic [PORTS-1:0]              link_up;
    logic [PORTS-1:0]              tx_done;
    logic                          rp_valid;
    logic [31:0]                   rp_addr;
    logic [31:0]                   rp_data;
    logic                          mem_we;
    logic [ADDR_W-1:0]             mem_addr;
    logic [31:0]                   mem_wdata;
    logic [BLOCKS-1:0]             blk_busy;
    logic [PORTS-1:0]              tx_pending;
    logic [PORTS-1:0][BLK_W-1:0]   tx_head_blk;
    logic [PORTS-1:0][BC_W-1:0]    tx_head_bc;
    logic [PORTS-1:0]              tx_head_crc;
    logic                          eop_mask_viol;
    logic                          eop_bad;

    int total = 0;
    int bad   = 0;
    int n_rep = 0;
    logic [31:0] ring_base = 32'h0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    pic_ingress_ctl dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] k, input logic [31:0] d, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        hw_valid = 1'b1; hw_kind = k; hw_data = d; hw_addr = a;
        @(negedge clk);
        hw_valid = 1'b0;
    endtask

    task automatic pulse_done(input logic [PORTS-1:0] m);
        @(negedge clk);
        tx_done = m;
        @(negedge clk);
        tx_done = '0;
    endtask

    function automatic logic [31:0] req_w(input logic [7:0] m, input logic [11:0] bc);
        return {12'h0, bc, m};
    endfunction

    function automatic logic [31:0] eop_w(input logic [11:0] bc, input logic [2:0] blk,
                                          input logic [2:0] port, input logic crc,
                                          input logic mc, input logic [7:0] m);
        return {2'b00, m, mc, crc, 1'b0, port, 1'b0, blk, bc};
    endfunction

    // issue a request and check ring address plus reply word
    task automatic request(input string req, input logic [7:0] m, input logic [11:0] bc,
                           input logic [31:0] exp_word);
        send(2'd1, req_w(m, bc), '0);
        chk({req, " valid"}, {31'b0, rp_valid}, 32'd1);
        chk("R4 ring address", rp_addr, ring_base + 32'(4 * (n_rep % 32)));
        chk({req, " reply"}, rp_data, exp_word);
        n_rep++;
    endtask

    task automatic t_reset();
        chk("R1 busy", {24'b0, blk_busy}, 32'h0);
        chk("R1 pending", {24'b0, tx_pending}, 32'h0);
        chk("R1 outputs", {28'b0, rp_valid, mem_we, eop_mask_viol, eop_bad}, 32'h0);
    endtask

    task automatic t_cfg();
        ring_base = 32'h0000_8000;
        send(2'd0, ring_base, '0);
        chk("R12 no reply on config", {31'b0, rp_valid}, 32'h0);
    endtask

    task automatic t_unicast();
        link_up = 8'hFF;
        request("R2 grant", 8'h01, 12'd64, {8'h0, 8'h01, 4'h0, 12'd64});
        chk("R2 busy", {24'b0, blk_busy}, 32'h01);
        send(2'd2, 32'hCAFE_0001, 9'd3);
        chk("R5 write fwd", {31'b0, mem_we}, 32'd1);
        chk("R5 write addr", {23'b0, mem_addr}, 32'd3);
        chk("R5 write data", mem_wdata, 32'hCAFE_0001);
        send(2'd2, 32'h1234_5678, {3'd5, 6'd0});
        chk("R5 drop to idle block", {31'b0, mem_we}, 32'd0);
        send(2'd3, eop_w(12'd64, 3'd0, 3'd0, 1'b1, 1'b0, 8'h00), '0);
        chk("R6 pending", {24'b0, tx_pending}, 32'h01);
        chk("R6 head", {19'b0, tx_head_crc[0], tx_head_bc[0], 1'b0, tx_head_blk[0]},
            {19'b0, 1'b1, 12'd64, 4'd0});
        chk("R8 no viol", {31'b0, eop_mask_viol}, 32'd0);
        pulse_done(8'h01);
        chk("R11 released", {24'b0, blk_busy}, 32'h0);
        chk("R10 drained", {24'b0, tx_pending}, 32'h0);
    endtask

    task automatic t_multicast();
        link_up = 8'hFB;
        request("R2 masked grant", 8'h0F, 12'd100, {8'h0, 8'h0B, 4'h0, 12'd100});
        send(2'd3, eop_w(12'd100, 3'd0, 3'd0, 1'b0, 1'b1, 8'h1B), '0);
        chk("R8 viol pulse", {31'b0, eop_mask_viol}, 32'd1);
        chk("R7 multicast ports", {24'b0, tx_pending}, 32'h0B);
        pulse_done(8'h03);
        chk("R11 held by port3", {24'b0, blk_busy}, 32'h01);
        chk("R11 pending left", {24'b0, tx_pending}, 32'h08);
        pulse_done(8'h08);
        chk("R11 released last", {24'b0, blk_busy}, 32'h0);
        link_up = 8'hFF;
    endtask

    task automatic t_deny_link();
        link_up = 8'h00;
        request("R3 link down", 8'h01, 12'd50, 32'h0);
        chk("R3 no alloc", {24'b0, blk_busy}, 32'h0);
        link_up = 8'hFF;
    endtask

    task automatic t_bad_eop();
        send(2'd3, eop_w(12'd9, 3'd2, 3'd1, 1'b0, 1'b0, 8'h00), '0);
        chk("R9 bad pulse", {31'b0, eop_bad}, 32'd1);
        chk("R9 no queue", {24'b0, tx_pending}, 32'h0);
        chk("R9 no block", {24'b0, blk_busy}, 32'h0);
    endtask

    task automatic t_order();
        request("R2 first", 8'h20, 12'd10, {8'h0, 8'h20, 4'h0, 12'd10});
        request("R2 second", 8'h20, 12'd20, {8'h0, 8'h20, 4'h1, 12'd20});
        send(2'd3, eop_w(12'd10, 3'd1, 3'd5, 1'b0, 1'b0, 8'h00), '0);
        send(2'd3, eop_w(12'd20, 3'd0, 3'd5, 1'b1, 1'b0, 8'h00), '0);
        chk("R10 head first", {17'b0, tx_head_bc[5], tx_head_blk[5]}, {17'b0, 12'd10, 3'd1});
        pulse_done(8'h20);
        chk("R10 head second", {16'b0, tx_head_crc[5], tx_head_bc[5], tx_head_blk[5]},
            {16'b0, 1'b1, 12'd20, 3'd0});
        chk("R11 first freed", {24'b0, blk_busy}, 32'h01);
        pulse_done(8'h20);
        chk("R11 both freed", {24'b0, blk_busy}, 32'h0);
        pulse_done(8'h20);
        chk("R10 done on empty", {16'b0, tx_pending, blk_busy}, 32'h0);
    endtask

    task automatic t_empty_final();
        request("R2 grant p1", 8'h02, 12'd30, {8'h0, 8'h02, 4'h0, 12'd30});
        send(2'd3, eop_w(12'd30, 3'd0, 3'd3, 1'b0, 1'b0, 8'h00), '0);
        chk("R8 unicast viol", {31'b0, eop_mask_viol}, 32'd1);
        chk("R8 port dropped", {24'b0, tx_pending}, 32'h0);
        chk("R11 empty release", {24'b0, blk_busy}, 32'h0);
    endtask

    task automatic t_full();
        for (int i = 0; i < BLOCKS; i++)
            request("R2 fill", 8'h01, 12'd1, {8'h0, 8'h01, 1'b0, 3'(i), 12'd1});
        chk("R2 all busy", {24'b0, blk_busy}, 32'hFF);
        request("R3 pool full", 8'h01, 12'd1, 32'h0);
        for (int i = 0; i < BLOCKS; i++)
            send(2'd3, eop_w(12'd1, 3'(i), 3'd1, 1'b0, 1'b0, 8'h00), '0);
        chk("R11 all released", {24'b0, blk_busy}, 32'h0);
    endtask

    task automatic t_wrap();
        link_up = 8'h00;
        while (n_rep < 34) request("R4 wrap", 8'h01, 12'd1, 32'h0);
        ring_base = 32'h0000_9000;
        send(2'd0, ring_base, '0);
        request("R12 new base", 8'h01, 12'd1, 32'h0);
        link_up = 8'hFF;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; hw_valid = 1'b0; hw_kind = '0; hw_data = '0; hw_addr = '0;
        link_up = '0; tx_done = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_unicast();
        t_multicast();
        t_deny_link();
        t_bad_eop();
        t_order();
        t_empty_final();
        t_full();
        t_wrap();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule